// File: doc/BRIEF.md
# RTC Prescaler with BCD Seconds Counter

This block is the first stage of a real-time clock. A single-cycle enable, pulsed at 128 Hz in the system clock domain, drives a seven-stage binary divider. The stages run at 64, 32, 16, 8, 4, 2 and 1 Hz. Software can read the divider as a register. When the slowest stage rolls over, the divider gives a once-per-second carry, and that carry advances a two-digit BCD seconds counter. When the seconds counter wraps, it sends a minute carry to the next stage.

Software controls the block with three inputs. A run enable lets time advance. A clear input and an adjust input each zero the divider. The seconds register can be written directly, and the intended use is to write it while the run enable is low. Chip reset leaves both time registers alone. Only the minute carry output depends on reset.

Top module: `rtc_prescale_sec`

## Requirements
- R1: Bit 7 of `div_state` and bit 7 of `sec_value` always read 0, even after bit 7 of the write data is set.
- R2: Each 128 Hz tick accepted while running increments `div_state[6:0]` by one, modulo 128. So bit k is the stage at 64/2^k Hz: bit 0 is 64 Hz and bit 6 is 1 Hz.
- R3: If `ctl_clr` or `ctl_adj` is high at a clock edge, `div_state` is 0x00 after that edge, even when a tick arrives in the same cycle.
- R4: The synchronous chip reset `rst` changes neither `div_state` nor `sec_value`. Counting continues through it.
- R5: While `ctl_run` is 0, ticks change nothing. They are dropped, not held for later.
- R6: `sec_value` advances by one at the same edge where a tick moves the divider from 0x7F to 0x00. At no other time does it change, except by a write.
- R7: `sec_value` is BCD, with tens in bits 6:4 and units in bits 3:0. Units wrap from 9 to 0 and carry into tens. 59 wraps to 00.
- R8: A write (`sec_wr_en`) stores `sec_wr_data[6:0]` at the next edge, whether the block is running or not. If a second carry falls in the same cycle, the write wins.
- R9: `min_carry` is high for exactly the one cycle in which `sec_value` first shows 00 after a 59-to-00 wrap. It is 0 in any cycle that follows an edge where `rst` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high chip reset; only clears the minute carry |
| tick_128 | input | 1 | Single-cycle 128 Hz enable |
| ctl_run | input | 1 | Run enable for divider and seconds |
| ctl_clr | input | 1 | Clears the divider |
| ctl_adj | input | 1 | Adjust; also clears the divider |
| sec_wr_en | input | 1 | Seconds register write strobe |
| sec_wr_data | input | 8 | Seconds write value, BCD; bit 7 ignored |
| div_state | output | 8 | Divider stage register, bit 7 zero |
| sec_value | output | 8 | BCD seconds, bit 7 zero |
| min_carry | output | 1 | One-cycle pulse on the 59-to-00 wrap |

## Verification
The hardest case to reach is a collision at the divider's terminal count. In that cycle the second carry coincides with a write, a reset or a clear. A carry happens only once every 128 accepted ticks.

The bench reaches that cycle in a fixed way. It clears the divider and then issues exactly 127 ticks, which parks the divider at 0x7F. It then drives the colliding input in the same cycle as the final tick. Table vectors run from preloaded seconds values such as 09, 58 and 59. This exercises digit carries and minute wraps in a few thousand cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W = 8;
  localparam int DIV_STAGES_DEF = 7;
  localparam int TENS_LAST_DEF = 5;
  localparam int UNITS_LAST_DEF = 9;
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int STAGES = rtc_pkg::DIV_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              clr_i,
  output logic [STAGES-1:0] stage_o,
  output logic              carry_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES:0]   ripple;

  assign ripple[0] = tick_i & run_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign ripple[i+1] = ripple[i] & stage_q[i];
    always_ff @(posedge clk) begin
      if (clr_i)          stage_q[i] <= 1'b0;
      else if (ripple[i]) stage_q[i] <= ~stage_q[i];
    end
  end

  assign carry_o = ripple[STAGES] & ~clr_i;
  assign stage_o = stage_q;

  p_clear_r3: assert property (@(posedge clk) clr_i |=> (stage_q == '0));
  p_halt_r5:  assert property (@(posedge clk) (!run_i && !clr_i) |=> $stable(stage_q));
  p_step_r2:  assert property (@(posedge clk) (run_i && tick_i && !clr_i)
                               |=> (stage_q == STAGES'($past(stage_q) + 1'b1)));
  p_idle_r2:  assert property (@(posedge clk) (!tick_i && !clr_i) |=> $stable(stage_q));
endmodule

// File: rtl/rtc_bcd_sec.sv
module rtc_bcd_sec #(
  parameter int TENS_LAST  = rtc_pkg::TENS_LAST_DEF,
  parameter int UNITS_LAST = rtc_pkg::UNITS_LAST_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_i,
  input  logic                wr_i,
  input  logic [TW+UW-1:0]    wr_data_i,
  output logic [TW+UW-1:0]    value_o,
  output logic                carry_o
);
  localparam int TW = $clog2(TENS_LAST + 1);
  localparam int UW = $clog2(UNITS_LAST + 1);

  logic [TW-1:0] tens_q;
  logic [UW-1:0] units_q;
  logic          carry_q;
  logic          units_wrap, tens_wrap;

  assign units_wrap = (units_q == UW'(UNITS_LAST));
  assign tens_wrap  = (tens_q  == TW'(TENS_LAST));

  always_ff @(posedge clk) begin
    if (wr_i) begin
      tens_q  <= wr_data_i[TW+UW-1:UW];
      units_q <= wr_data_i[UW-1:0];
    end else if (step_i) begin
      if (units_wrap) begin
        units_q <= '0;
        tens_q  <= tens_wrap ? '0 : tens_q + 1'b1;
      end else begin
        units_q <= units_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= step_i & ~wr_i & units_wrap & tens_wrap;
  end

  assign value_o = {tens_q, units_q};
  assign carry_o = carry_q;

  p_write_r8: assert property (@(posedge clk) wr_i |=> (value_o == $past(wr_data_i)));
  p_hold_r6:  assert property (@(posedge clk) (!wr_i && !step_i) |=> $stable(value_o));
  p_wrap_r7:  assert property (@(posedge clk) disable iff (rst) carry_q |-> (value_o == '0));
  p_pulse_r9: assert property (@(posedge clk) disable iff (rst) carry_q |=> !carry_q);
endmodule

// File: rtl/rtc_prescale_sec.sv
module rtc_prescale_sec #(
  parameter int DIV_STAGES = rtc_pkg::DIV_STAGES_DEF,
  parameter int TENS_LAST  = rtc_pkg::TENS_LAST_DEF,
  parameter int UNITS_LAST = rtc_pkg::UNITS_LAST_DEF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_128,
  input  logic       ctl_run,
  input  logic       ctl_clr,
  input  logic       ctl_adj,
  input  logic       sec_wr_en,
  input  logic [7:0] sec_wr_data,
  output logic [7:0] div_state,
  output logic [7:0] sec_value,
  output logic       min_carry
);
  localparam int SW = $clog2(TENS_LAST + 1) + $clog2(UNITS_LAST + 1);

  logic [DIV_STAGES-1:0] stages;
  logic                  sec_step;
  logic [SW-1:0]         sec_bits;

  rtc_divider #(.STAGES(DIV_STAGES)) u_div (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_128),
    .run_i   (ctl_run),
    .clr_i   (ctl_clr | ctl_adj),
    .stage_o (stages),
    .carry_o (sec_step)
  );

  rtc_bcd_sec #(.TENS_LAST(TENS_LAST), .UNITS_LAST(UNITS_LAST)) u_sec (
    .clk       (clk),
    .rst       (rst),
    .step_i    (sec_step),
    .wr_i      (sec_wr_en),
    .wr_data_i (sec_wr_data[SW-1:0]),
    .value_o   (sec_bits),
    .carry_o   (min_carry)
  );

  assign div_state = {{(rtc_pkg::REG_W-DIV_STAGES){1'b0}}, stages};
  assign sec_value = {{(rtc_pkg::REG_W-SW){1'b0}}, sec_bits};

  p_sec_adv_r6: assert property (@(posedge clk)
    (sec_step && !sec_wr_en) |=> (div_state == 8'h00));
endmodule

// File: tb/rtc_prescale_sec_tb.sv
module rtc_prescale_sec_tb;
  logic clk = 0, rst = 1, tick_128 = 0, ctl_run = 0, ctl_clr = 0, ctl_adj = 0;
  logic sec_wr_en = 0;
  logic [7:0] sec_wr_data = 0;
  logic [7:0] div_state, sec_value;
  logic min_carry;
  int errors = 0, checks = 0, carries = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rtc_prescale_sec u_dut (.*);

  // {start_sec[8], ticks[16], exp_sec[8], exp_div[8], exp_carries[1]}
  localparam logic [40:0] VEC [9] = '{
    {8'h00, 16'd1,   8'h00, 8'h01, 1'b0},
    {8'h00, 16'd127, 8'h00, 8'h7F, 1'b0},
    {8'h00, 16'd128, 8'h01, 8'h00, 1'b0},
    {8'h09, 16'd128, 8'h10, 8'h00, 1'b0},
    {8'h59, 16'd128, 8'h00, 8'h00, 1'b1},
    {8'h58, 16'd256, 8'h00, 8'h00, 1'b1},
    {8'h19, 16'd200, 8'h20, 8'h48, 1'b0},
    {8'h42, 16'd384, 8'h45, 8'h00, 1'b0},
    {8'h55, 16'd640, 8'h00, 8'h00, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tick_128 = 1;
    @(negedge clk) tick_128 = 0;
    if (min_carry) carries++;
  endtask

  task automatic clr_div();
    @(negedge clk) ctl_clr = 1;
    @(negedge clk) ctl_clr = 0;
  endtask

  task automatic wr_sec(input logic [7:0] v);
    @(negedge clk) begin sec_wr_en = 1; sec_wr_data = v; end
    @(negedge clk) sec_wr_en = 0;
  endtask

  task automatic park(input logic [7:0] s);   // divider at 0x7F, seconds s
    ctl_run = 0;
    clr_div();
    wr_sec(s);
    ctl_run = 1;
    repeat (127) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R9 min_carry after reset", min_carry, 0);

    // Table walk: R2 R6 R7 R9
    foreach (VEC[i]) begin
      ctl_run = 0;
      clr_div();
      wr_sec(VEC[i][40:33]);
      ctl_run = 1;
      carries = 0;
      for (int t = 0; t < int'(VEC[i][32:17]); t++) tick();
      ctl_run = 0;
      chk("R6/R7 sec_value", sec_value, VEC[i][16:9]);
      chk("R2 div_state", div_state, VEC[i][8:1]);
      chk("R9 carry count", carries, VEC[i][0]);
    end

    // R1: bit 7 of write data dropped
    wr_sec(8'hC5);
    chk("R1 sec bit7", sec_value, 8'h45);
    chk("R1 div bit7", div_state[7], 0);

    // R5: halted ticks ignored and not queued
    clr_div();
    ctl_run = 1; repeat (5) tick(); ctl_run = 0;
    repeat (10) tick();
    chk("R5 halted div", div_state, 8'h05);
    chk("R5 halted sec", sec_value, 8'h45);
    ctl_run = 1; tick();
    chk("R5 resume one step", div_state, 8'h06);

    // R4: reset does not disturb time state
    @(negedge clk) rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R4 div after rst", div_state, 8'h06);
    chk("R4 sec after rst", sec_value, 8'h45);

    // R3: clear and adjust beat a coincident tick
    @(negedge clk) begin ctl_clr = 1; tick_128 = 1; end
    @(negedge clk) begin ctl_clr = 0; tick_128 = 0; end
    chk("R3 clr with tick", div_state, 8'h00);
    repeat (3) tick();
    @(negedge clk) begin ctl_adj = 1; tick_128 = 1; end
    @(negedge clk) begin ctl_adj = 0; tick_128 = 0; end
    chk("R3 adj with tick", div_state, 8'h00);

    // R8: write wins over same-cycle second carry, while running
    park(8'h20);
    @(negedge clk) begin sec_wr_en = 1; sec_wr_data = 8'h37; tick_128 = 1; end
    @(negedge clk) begin sec_wr_en = 0; tick_128 = 0; end
    chk("R8 write over step", sec_value, 8'h37);
    chk("R8 div rolled", div_state, 8'h00);

    // R9/R4: reset on the wrap cycle suppresses carry, not the wrap
    park(8'h59);
    @(negedge clk) begin rst = 1; tick_128 = 1; end
    @(negedge clk) begin rst = 0; tick_128 = 0; end
    chk("R4 wrap during rst", sec_value, 8'h00);
    chk("R9 carry suppressed", min_carry, 0);
    ctl_run = 0;

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule